// File: doc/BRIEF.md
# Autoincrement Address Unit with Rollback

This block turns operand requests into memory addresses for register-indirect addressing, working on a small file of pointer registers. A request names a register, an addressing mode and an access size. In post-increment mode the current register value is the address and the register then advances by the access size. In pre-decrement mode the register first steps back by the access size, and the new value is the address. A plain indirect mode leaves the register alone. The step is 2 for a 16-bit word and 1 for a byte, because memory is byte-addressed.

Since one instruction can move several pointers, a memory fault part-way through would leave the register file in a mixed state. The unit therefore keeps a per-register shadow copy. The first time an instruction modifies a register, the copy records the value that register held when the instruction began. A fault writes every modified register back from its copy, so the instruction can be restarted from scratch. A start strobe opens an instruction window and a commit strobe closes it. A separate write port loads registers from outside, and a combinational read port shows their contents.

Top module: `addr_rollback_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `addr_valid_o` is 0 and no register is marked as modified, so a fault has no effect.
- R2: A request taken with mode 1 (post-increment) gives `addr_valid_o`=1 one cycle later, with `addr_o` equal to the register's value before the request. The register then holds that value plus the step.
- R3: A request taken with mode 2 (pre-decrement) makes the register hold its old value minus the step one cycle later. `addr_o` equals that new value.
- R4: The step is 2 when `req_word_i`=1 and 1 when `req_word_i`=0.
- R5: A request with mode 0 or mode 3 (plain indirect) gives `addr_o` equal to the register's value and leaves the register unchanged.
- R6: Address and register arithmetic wraps modulo 2^16 (0xFFFF plus 1 is 0x0000, and 0x0000 minus 2 is 0xFFFE).
- R7: A fault restores every register modified by requests since the last start to its value at that start, one cycle after the fault.
- R8: A register modified several times in one instruction is restored to its value at instruction start, not to an intermediate value.
- R9: A request in the same cycle as a fault is dropped. It gives no `addr_valid_o` and changes no register.
- R10: After a commit, a fault changes no register.
- R11: The write port sets a register one cycle after `wr_en_i`, and a later fault does not undo that write. When a taken request and the write port target the same register in one cycle, the request's update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Instruction start; opens a new rollback window |
| commit_i | input | 1 | Instruction complete; closes the rollback window |
| fault_i | input | 1 | Memory access fault; restores modified registers |
| req_valid_i | input | 1 | Operand request strobe |
| req_reg_i | input | 3 | Register index of the request |
| req_mode_i | input | 2 | 0/3 plain, 1 post-increment, 2 pre-decrement |
| req_word_i | input | 1 | 1 for word access (step 2), 0 for byte (step 1) |
| wr_en_i | input | 1 | Register load strobe |
| wr_idx_i | input | 3 | Register index to load |
| wr_data_i | input | 16 | Value to load |
| rd_idx_i | input | 3 | Register index to read |
| rd_data_o | output | 16 | Current value of the selected register |
| addr_valid_o | output | 1 | Operand address valid |
| addr_o | output | 16 | Operand address |

## Verification
On every cycle the assertions check the per-request arithmetic. They cover the address produced in each mode and the register value after a post-increment, and they check that plain mode leaves the register unchanged. They also check that a fault suppresses the address strobe and that reset leaves the strobe low. Only the bench scenarios can show that rollback returns each register to its value at instruction start. The same goes for a register stepped several times, for a commit turning a later fault into a no-op, and for load-port writes surviving a fault. Each of these depends on a history spanning several requests.

// File: rtl/aru_pkg.sv
// Package: shared addressing-mode encoding for the address unit.
// Assumes a 2-bit mode field; codes 0 and 3 both mean plain indirect.
package aru_pkg;
    typedef enum logic [1:0] {
        AM_PLAIN   = 2'd0,
        AM_POSTINC = 2'd1,
        AM_PREDEC  = 2'd2,
        AM_PLAIN2  = 2'd3
    } amode_e;
endpackage

// File: rtl/aru_step.sv
// Module: aru_step
// Computes the operand address and the updated pointer value for one
// request. Purely combinational. Assumes DW-bit wrapping arithmetic.
module aru_step
    import aru_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] cur_i,
    input  logic [1:0]    mode_i,
    input  logic          word_i,
    output logic [DW-1:0] addr_o,
    output logic [DW-1:0] next_o,
    output logic          writes_o
);
    logic [DW-1:0] step;

    // Access size selects the pointer step.
    always_comb step = word_i ? DW'(2) : DW'(1);

    // Mode selects the address and the pointer update.
    always_comb begin
        unique case (amode_e'(mode_i))
            AM_POSTINC: begin
                addr_o   = cur_i;
                next_o   = cur_i + step;
                writes_o = 1'b1;
            end
            AM_PREDEC: begin
                next_o   = cur_i - step;
                addr_o   = cur_i - step;
                writes_o = 1'b1;
            end
            default: begin
                addr_o   = cur_i;
                next_o   = cur_i;
                writes_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/aru_slot.sv
// Module: aru_slot
// One pointer register with its rollback shadow and modified flag.
// The shadow is captured on the first request update after the window
// opens, so it always holds the value from instruction start.
// Assumes op_hit_i is already masked off in a fault cycle.
module aru_slot #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          restore_i,
    input  logic          op_hit_i,
    input  logic [DW-1:0] op_val_i,
    input  logic          wr_hit_i,
    input  logic [DW-1:0] wr_val_i,
    output logic [DW-1:0] value_o
);
    logic [DW-1:0] val_q;
    logic [DW-1:0] shadow_q;
    logic          dirty_q;
    logic          first_touch;

    // A request update is the first in this window if the flag is clear
    // or is being cleared in this same cycle.
    always_comb first_touch = op_hit_i && (clear_i || !dirty_q);

    // Register value: restore, then request update, then load port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (restore_i && dirty_q) begin
            val_q <= shadow_q;
        end else if (op_hit_i) begin
            val_q <= op_val_i;
        end else if (wr_hit_i) begin
            val_q <= wr_val_i;
        end
    end

    // Shadow copy: records the pre-update value on first touch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (first_touch && !restore_i) begin
            shadow_q <= val_q;
        end
    end

    // Modified flag: set by request updates, cleared by start, commit or fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= 1'b0;
        end else if (restore_i) begin
            dirty_q <= 1'b0;
        end else begin
            dirty_q <= op_hit_i || (dirty_q && !clear_i);
        end
    end

    assign value_o = val_q;
endmodule

// File: rtl/addr_rollback_unit.sv
// Module: addr_rollback_unit
// Top of the autoincrement address unit. Holds NREG pointer slots,
// computes operand addresses and undoes pointer side effects on a fault.
// Assumes NREG is a power of two; a fault masks a same-cycle request.
module addr_rollback_unit
    import aru_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          commit_i,
    input  logic          fault_i,
    input  logic          req_valid_i,
    input  logic [IW-1:0] req_reg_i,
    input  logic [1:0]    req_mode_i,
    input  logic          req_word_i,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [IW-1:0] rd_idx_i,
    output logic [DW-1:0] rd_data_o,
    output logic          addr_valid_o,
    output logic [DW-1:0] addr_o
);
    logic [NREG-1:0][DW-1:0] reg_vec;
    logic                    take;
    logic                    clear;
    logic [DW-1:0]           cur;
    logic [DW-1:0]           step_addr;
    logic [DW-1:0]           step_next;
    logic                    step_writes;

    // A request is accepted only when no fault arrives with it.
    always_comb take = req_valid_i && !fault_i;

    // Start and commit both close the current rollback window.
    always_comb clear = start_i || commit_i;

    // Select the requested pointer.
    always_comb cur = reg_vec[req_reg_i];

    aru_step #(.DW(DW)) u_step (
        .cur_i    (cur),
        .mode_i   (req_mode_i),
        .word_i   (req_word_i),
        .addr_o   (step_addr),
        .next_o   (step_next),
        .writes_o (step_writes)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        logic op_hit;
        logic wr_hit;

        // Route the request update and the load port to this slot.
        always_comb begin
            op_hit = take && step_writes && (req_reg_i == IW'(g));
            wr_hit = wr_en_i && (wr_idx_i == IW'(g));
        end

        aru_slot #(.DW(DW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear_i   (clear),
            .restore_i (fault_i),
            .op_hit_i  (op_hit),
            .op_val_i  (step_next),
            .wr_hit_i  (wr_hit),
            .wr_val_i  (wr_data_i),
            .value_o   (reg_vec[g])
        );
    end

    // Registered operand address and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid_o <= 1'b0;
            addr_o       <= '0;
        end else begin
            addr_valid_o <= take;
            if (take) begin
                addr_o <= step_addr;
            end
        end
    end

    // Combinational read port.
    always_comb rd_data_o = reg_vec[rd_idx_i];
endmodule

// File: rtl/aru_checker.sv
// Module: aru_checker
// Cycle-level properties of the address unit, attached by bind.
// Assumes the default configuration of the top module.
module aru_checker
    import aru_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 16,
    localparam int IW  = $clog2(NREG)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    fault_i,
    input logic                    req_valid_i,
    input logic [IW-1:0]           req_reg_i,
    input logic [1:0]              req_mode_i,
    input logic                    req_word_i,
    input logic                    wr_en_i,
    input logic [IW-1:0]           wr_idx_i,
    input logic                    addr_valid_o,
    input logic [DW-1:0]           addr_o,
    input logic [NREG-1:0][DW-1:0] reg_vec
);
    logic          ok;
    logic [DW-1:0] cv;
    logic [DW-1:0] st;
    logic          is_plain;

    // Observed request fields for the properties.
    always_comb begin
        ok       = req_valid_i && !fault_i;
        cv       = reg_vec[req_reg_i];
        st       = req_word_i ? DW'(2) : DW'(1);
        is_plain = (req_mode_i == AM_PLAIN) || (req_mode_i == AM_PLAIN2);
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !addr_valid_o); // R1
    AST_REQ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ok |=> addr_valid_o); // R2
    AST_POST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && req_mode_i == AM_POSTINC) |=> addr_o == $past(cv)); // R2
    AST_POST_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && req_mode_i == AM_POSTINC) |=> reg_vec[$past(req_reg_i)] == $past(cv + st)); // R4
    AST_PRE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && req_mode_i == AM_PREDEC) |=> addr_o == $past(cv - st)); // R3
    AST_PLAIN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && is_plain) |=> addr_o == $past(cv)); // R5
    AST_PLAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && is_plain && !(wr_en_i && wr_idx_i == req_reg_i))
        |=> reg_vec[$past(req_reg_i)] == $past(cv)); // R5
    AST_FAULT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> !addr_valid_o); // R9
endmodule

bind addr_rollback_unit aru_checker u_chk (.*);

// File: tb/sim_addr_rollback_unit.sv
module sim_addr_rollback_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, commit_i = 1'b0, fault_i = 1'b0;
    logic        req_valid_i = 1'b0, req_word_i = 1'b0, wr_en_i = 1'b0;
    logic [2:0]  req_reg_i = '0, wr_idx_i = '0, rd_idx_i = '0;
    logic [1:0]  req_mode_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] rd_data_o, addr_o;
    logic        addr_valid_o;
    int          n_chk = 0, n_err = 0;

    always #10 clk = ~clk;

    addr_rollback_unit u0 (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input int idx, input logic [15:0] exp, input string tag);
        rd_idx_i = 3'(idx);
        #1;
        chk(tag, rd_data_o, exp);
    endtask

    task automatic wr(input int idx, input logic [15:0] v);
        wr_en_i = 1'b1; wr_idx_i = 3'(idx); wr_data_i = v;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic pulse_start();
        start_i = 1'b1; tick(); start_i = 1'b0;
    endtask

    task automatic pulse_commit();
        commit_i = 1'b1; tick(); commit_i = 1'b0;
    endtask

    task automatic pulse_fault();
        fault_i = 1'b1; tick(); fault_i = 1'b0;
    endtask

    task automatic op(input int idx, input int mode, input bit word);
        req_valid_i = 1'b1; req_reg_i = 3'(idx);
        req_mode_i = 2'(mode); req_word_i = word;
        tick();
        req_valid_i = 1'b0;
    endtask

    function automatic logic [15:0] pick(input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h0002;
            3: return 16'h7FFF;
            4: return 16'hFFFF;
            5: return 16'hFFFE;
            default: return 16'h1234;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        tick(); tick(); tick();
        // R1: reset state
        chk("R1 valid", addr_valid_o, 0);
        for (int i = 0; i < 8; i++) rd(i, 16'h0, "R1 reg");
        rst_n = 1'b1;
        tick();
        pulse_fault();
        rd(0, 16'h0, "R1 fault after reset");

        // Sweep: register x mode x size x value
        for (int r = 0; r < 8; r++)
            for (int m = 0; m < 4; m++)
                for (int w = 0; w < 2; w++)
                    for (int k = 0; k < 7; k++) begin
                        logic [15:0] v, st, nv, ea;
                        logic [16:0] wide;
                        string tg;
                        v  = pick(k);
                        st = (w == 1) ? 16'd2 : 16'd1;
                        wide = {1'b0, v} + {1'b0, st};
                        if (m == 1) begin nv = v + st; ea = v; tg = wide[16] ? "R6 post wrap" : "R2 post"; end
                        else if (m == 2) begin nv = v - st; ea = nv; tg = (v < st) ? "R6 pre wrap" : "R3 pre"; end
                        else begin nv = v; ea = v; tg = "R5 plain"; end
                        wr(r, v);
                        pulse_start();
                        op(r, m, bit'(w));
                        chk({tg, " valid"}, addr_valid_o, 1);
                        chk({tg, " addr"}, addr_o, ea);
                        rd(r, nv, {tg, " reg"});
                        if (k % 2 == 0) begin
                            pulse_fault();
                            rd(r, v, "R7 restore");
                        end else begin
                            pulse_commit();
                            pulse_fault();
                            rd(r, nv, "R10 no undo after commit");
                        end
                    end

        // R4: byte vs word step on the same register
        wr(1, 16'h0100);
        op(1, 1, 1'b0);
        rd(1, 16'h0101, "R4 byte step");
        op(1, 1, 1'b1);
        rd(1, 16'h0103, "R4 word step");

        // R7: two registers, post-increment and pre-decrement
        wr(2, 16'h0100); wr(3, 16'h0200);
        pulse_start();
        op(2, 1, 1'b1);
        op(3, 2, 1'b1);
        chk("R7 pre addr", addr_o, 16'h01FE);
        rd(2, 16'h0102, "R7 r2 mid");
        rd(3, 16'h01FE, "R7 r3 mid");
        pulse_fault();
        rd(2, 16'h0100, "R7 r2 restored");
        rd(3, 16'h0200, "R7 r3 restored");

        // R8: one register stepped three times
        wr(4, 16'h0050);
        pulse_start();
        op(4, 1, 1'b1); op(4, 1, 1'b0); op(4, 2, 1'b1);
        rd(4, 16'h0051, "R8 after three steps");
        pulse_fault();
        rd(4, 16'h0050, "R8 start value");

        // R9: request in the fault cycle is dropped
        wr(5, 16'h0300); wr(2, 16'h0400);
        pulse_start();
        op(2, 1, 1'b1);
        req_valid_i = 1'b1; req_reg_i = 3'd5; req_mode_i = 2'd1; req_word_i = 1'b1;
        fault_i = 1'b1;
        tick();
        req_valid_i = 1'b0; fault_i = 1'b0;
        chk("R9 no valid", addr_valid_o, 0);
        rd(5, 16'h0300, "R9 r5 untouched");
        rd(2, 16'h0400, "R9 r2 restored");

        // R11: load port survives a fault; request beats load
        wr(6, 16'h0010);
        pulse_start();
        wr(6, 16'h0020);
        pulse_fault();
        rd(6, 16'h0020, "R11 load kept");
        wr_en_i = 1'b1; wr_idx_i = 3'd6; wr_data_i = 16'hAAAA;
        req_valid_i = 1'b1; req_reg_i = 3'd6; req_mode_i = 2'd2; req_word_i = 1'b0;
        tick();
        wr_en_i = 1'b0; req_valid_i = 1'b0;
        rd(6, 16'h001F, "R11 request wins");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule